// File: doc/BRIEF.md
# Privilege-Mode Address Segment Decoder

This block sits in front of the translation buffer of a 32-bit processor's memory pipeline. Each request carries a virtual address, the two-bit privilege field, the error-level and exception-level status bits, and a flag for load or store. The block first works out the effective privilege. It then sorts the address into one of three outcomes: a direct (unmapped) window with a physical address computed on the spot, an address error, or a request that the translation buffer must resolve.

The result appears one clock after the request and is qualified by a valid strobe. A direct hit reports whether the window is cacheable. An address error reports whether the faulting access was a load or a store, so that the exception logic can pick the matching cause. The translation buffer and the exception sequencing sit downstream and are not part of this block.

Top module: `vseg_decode`

## Requirements
- R1: When either `st_erl` or `st_exl` is 1, the effective privilege is kernel, whatever the value of `st_ksu`.
- R2: Privilege encoding on `st_ksu`: 0 is kernel, 1 is supervisor and 2 is user. The reserved code 3 is handled exactly like kernel.
- R3: In kernel mode, an address from 0x80000000 to 0x9FFFFFFF is direct and cacheable: `rsp_direct`=1, `rsp_cached`=1, and `rsp_paddr` = vaddr − 0x80000000.
- R4: In kernel mode, an address from 0xA0000000 to 0xBFFFFFFF is direct and uncached: `rsp_direct`=1, `rsp_cached`=0, and `rsp_paddr` = vaddr − 0xA0000000.
- R5: In kernel mode, every address outside 0x80000000 to 0xBFFFFFFF raises `rsp_tlb_req`.
- R6: In supervisor mode, an address whose top three bits are 000 or 110 raises `rsp_tlb_req`. Any other address raises `rsp_addr_err`.
- R7: In user mode, an address with bit 31 set raises `rsp_addr_err`. Any other address raises `rsp_tlb_req`.
- R8: On an address error, `rsp_err_store` equals the request's `req_store` (1 = store, 0 = load). Outside an error it is 0.
- R9: `rsp_valid` rises exactly one clock after a cycle with `req_valid`=1 and is 0 otherwise, including after reset. While `rsp_valid` is 0, all flags and `rsp_paddr` are 0.
- R10: With `rsp_valid`=1, exactly one of `rsp_tlb_req`, `rsp_direct` and `rsp_addr_err` is 1. `rsp_cached` is 1 only together with `rsp_direct`, and `rsp_paddr` is 0 unless `rsp_direct` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | ADDR_W | Virtual address |
| req_store | input | 1 | 1 = store, 0 = load |
| st_ksu | input | 2 | Privilege field (0 kernel, 1 supervisor, 2 user, 3 kernel) |
| st_erl | input | 1 | Error-level status bit |
| st_exl | input | 1 | Exception-level status bit |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_tlb_req | output | 1 | Address must be translated by the buffer |
| rsp_direct | output | 1 | Address is in a direct window |
| rsp_cached | output | 1 | Direct window is cacheable |
| rsp_paddr | output | ADDR_W | Physical address for a direct hit, else 0 |
| rsp_addr_err | output | 1 | Address error for this privilege |
| rsp_err_store | output | 1 | Error came from a store (0 = load) |

## Verification
Addresses are driven at the exact edges of each window: the first and last word of both direct windows, the words just outside them, and the three-bit boundaries at 0x20000000, 0xC0000000 and 0xE0000000. Each is paired with every privilege code. Setting the error-level or exception-level bit on a user or supervisor request with a direct-window address separates a correct forcing from a design that only looks at the privilege field. Code 3 with the same addresses shows whether it is folded into kernel. Loads and stores to identical faulting addresses tell the two error kinds apart. Back-to-back requests and idle gaps, with an address left on the bus that would otherwise decode as a direct hit, expose latency errors and leakage from idle cycles.

// File: rtl/vseg_pkg.sv
package vseg_pkg;

    typedef enum logic [1:0] {
        PRIV_KERNEL = 2'd0,
        PRIV_SUPER  = 2'd1,
        PRIV_USER   = 2'd2
    } priv_e;

    typedef struct packed {
        logic tlb_req;
        logic direct;
        logic cached;
        logic addr_err;
        logic err_store;
    } seg_class_t;

    localparam seg_class_t SEG_CLASS_NONE = '{default: 1'b0};

    // Three-bit region codes at the top of the address.
    localparam logic [2:0] TOP_LOW_SUPER  = 3'b000;
    localparam logic [2:0] TOP_HIGH_SUPER = 3'b110;
    localparam logic [1:0] TOP_DIRECT     = 2'b10;

    function automatic priv_e fold_priv(input logic [1:0] ksu,
                                        input logic erl,
                                        input logic exl);
        priv_e p;
        if (erl || exl) begin
            p = PRIV_KERNEL;
        end else begin
            unique case (ksu)
                2'd1:    p = PRIV_SUPER;
                2'd2:    p = PRIV_USER;
                default: p = PRIV_KERNEL;
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/vseg_priv.sv
module vseg_priv
    import vseg_pkg::*;
(
    input  logic [1:0] ksu,
    input  logic       erl,
    input  logic       exl,
    output priv_e      priv
);
    always_comb begin
        priv = fold_priv(ksu, erl, exl);
    end
endmodule

// File: rtl/vseg_region.sv
module vseg_region
    import vseg_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  priv_e              priv,
    input  logic [ADDR_W-1:0]  vaddr,
    input  logic               is_store,
    output seg_class_t         cls,
    output logic [ADDR_W-1:0]  paddr
);
    localparam int unsigned MSB   = ADDR_W - 1;
    localparam int unsigned OFS_W = ADDR_W - 3;

    logic [2:0] top3;
    logic       in_direct;
    logic       super_ok;

    assign top3      = vaddr[MSB -: 3];
    assign in_direct = (top3[2:1] == TOP_DIRECT);
    assign super_ok  = (top3 == TOP_LOW_SUPER) || (top3 == TOP_HIGH_SUPER);

    always_comb begin
        cls   = SEG_CLASS_NONE;
        paddr = '0;
        unique case (priv)
            PRIV_KERNEL: begin
                if (in_direct) begin
                    cls.direct         = 1'b1;
                    cls.cached         = ~top3[0];
                    // Both windows are 2**OFS_W aligned: subtracting the base clears the top bits.
                    paddr[OFS_W-1:0]   = vaddr[OFS_W-1:0];
                end else begin
                    cls.tlb_req = 1'b1;
                end
            end
            PRIV_SUPER: begin
                if (super_ok) cls.tlb_req  = 1'b1;
                else          cls.addr_err = 1'b1;
            end
            default: begin
                if (vaddr[MSB]) cls.addr_err = 1'b1;
                else            cls.tlb_req  = 1'b1;
            end
        endcase
        cls.err_store = cls.addr_err & is_store;
    end
endmodule

// File: rtl/vseg_outreg.sv
module vseg_outreg
    import vseg_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  seg_class_t         in_cls,
    input  logic [ADDR_W-1:0]  in_paddr,
    output logic               out_valid,
    output seg_class_t         out_cls,
    output logic [ADDR_W-1:0]  out_paddr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_cls   <= SEG_CLASS_NONE;
            out_paddr <= '0;
        end else if (in_valid) begin
            out_valid <= 1'b1;
            out_cls   <= in_cls;
            out_paddr <= in_paddr;
        end else begin
            out_valid <= 1'b0;
            out_cls   <= SEG_CLASS_NONE;
            out_paddr <= '0;
        end
    end
endmodule

// File: rtl/vseg_decode.sv
module vseg_decode
    import vseg_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_store,
    input  logic [1:0]        st_ksu,
    input  logic              st_erl,
    input  logic              st_exl,
    output logic              rsp_valid,
    output logic              rsp_tlb_req,
    output logic              rsp_direct,
    output logic              rsp_cached,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_addr_err,
    output logic              rsp_err_store
);
    priv_e             priv;
    seg_class_t        cls_d;
    seg_class_t        cls_q;
    logic [ADDR_W-1:0] paddr_d;

    vseg_priv u_priv (
        .ksu  (st_ksu),
        .erl  (st_erl),
        .exl  (st_exl),
        .priv (priv)
    );

    vseg_region #(.ADDR_W(ADDR_W)) u_region (
        .priv     (priv),
        .vaddr    (req_vaddr),
        .is_store (req_store),
        .cls      (cls_d),
        .paddr    (paddr_d)
    );

    vseg_outreg #(.ADDR_W(ADDR_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_cls    (cls_d),
        .in_paddr  (paddr_d),
        .out_valid (rsp_valid),
        .out_cls   (cls_q),
        .out_paddr (rsp_paddr)
    );

    assign rsp_tlb_req   = cls_q.tlb_req;
    assign rsp_direct    = cls_q.direct;
    assign rsp_cached    = cls_q.cached;
    assign rsp_addr_err  = cls_q.addr_err;
    assign rsp_err_store = cls_q.err_store;
endmodule

// File: rtl/vseg_decode_chk.sv
module vseg_decode_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic              req_store,
    input logic [1:0]        st_ksu,
    input logic              st_erl,
    input logic              st_exl,
    input logic              rsp_valid,
    input logic              rsp_tlb_req,
    input logic              rsp_direct,
    input logic              rsp_cached,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic              rsp_addr_err,
    input logic              rsp_err_store
);
    localparam int unsigned MSB = ADDR_W - 1;

    // R9: strobe follows the request by one cycle
    p_strobe_rise_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_strobe_fall_r9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !(rsp_tlb_req || rsp_direct || rsp_addr_err || rsp_cached
                         || rsp_err_store) && (rsp_paddr == '0));

    // R10: one outcome per result
    p_one_class_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_tlb_req, rsp_direct, rsp_addr_err}) == 1);
    p_cached_direct_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_cached |-> rsp_direct);
    p_paddr_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !rsp_direct |-> rsp_paddr == '0);

    // R1: level bits force kernel
    p_level_force_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid && (st_erl || st_exl) && (req_vaddr[MSB -: 2] == 2'b10)
        |=> rsp_direct);

    // R2: reserved code behaves as kernel
    p_reserved_kernel_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid && (st_ksu == 2'd3) && (req_vaddr[MSB -: 2] == 2'b10)
        |=> rsp_direct);

    // R7: user upper half faults
    p_user_high_r7: assert property (@(posedge clk) disable iff (rst)
        req_valid && !st_erl && !st_exl && (st_ksu == 2'd2) && req_vaddr[MSB]
        |=> rsp_addr_err);

    // R8: fault kind follows the access kind
    p_err_kind_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_err_store == (rsp_addr_err && $past(req_store))));
endmodule

bind vseg_decode vseg_decode_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_store     (req_store),
    .st_ksu        (st_ksu),
    .st_erl        (st_erl),
    .st_exl        (st_exl),
    .rsp_valid     (rsp_valid),
    .rsp_tlb_req   (rsp_tlb_req),
    .rsp_direct    (rsp_direct),
    .rsp_cached    (rsp_cached),
    .rsp_paddr     (rsp_paddr),
    .rsp_addr_err  (rsp_addr_err),
    .rsp_err_store (rsp_err_store)
);

// File: tb/sim_vseg_decode.sv
module sim_vseg_decode;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_store = 1'b0;
    logic [1:0]  st_ksu = 2'd0;
    logic        st_erl = 1'b0;
    logic        st_exl = 1'b0;
    logic        rsp_valid, rsp_tlb_req, rsp_direct, rsp_cached;
    logic        rsp_addr_err, rsp_err_store;
    logic [31:0] rsp_paddr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic        tlb;
        logic        dir;
        logic        cac;
        logic [31:0] pa;
        logic        err;
        logic        est;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    vseg_decode u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_store(req_store), .st_ksu(st_ksu), .st_erl(st_erl), .st_exl(st_exl),
        .rsp_valid(rsp_valid), .rsp_tlb_req(rsp_tlb_req), .rsp_direct(rsp_direct),
        .rsp_cached(rsp_cached), .rsp_paddr(rsp_paddr), .rsp_addr_err(rsp_addr_err),
        .rsp_err_store(rsp_err_store)
    );

    function automatic exp_t model(input logic [31:0] va, input logic [1:0] ksu,
                                   input logic erl, input logic exl, input logic st,
                                   input string tag);
        exp_t e;
        bit kern;
        e.tlb = 0; e.dir = 0; e.cac = 0; e.pa = 0; e.err = 0; e.est = 0; e.tag = tag;
        kern = erl || exl || ksu == 2'd0 || ksu == 2'd3;
        if (kern) begin
            if (va >= 32'h8000_0000 && va < 32'hA000_0000) begin
                e.dir = 1; e.cac = 1; e.pa = va - 32'h8000_0000;
            end else if (va >= 32'hA000_0000 && va < 32'hC000_0000) begin
                e.dir = 1; e.pa = va - 32'hA000_0000;
            end else begin
                e.tlb = 1;
            end
        end else if (ksu == 2'd1) begin
            if (va < 32'h2000_0000 || (va >= 32'hC000_0000 && va < 32'hE000_0000)) e.tlb = 1;
            else e.err = 1;
        end else begin
            if (va < 32'h8000_0000) e.tlb = 1;
            else e.err = 1;
        end
        e.est = e.err && st;
        return e;
    endfunction

    task automatic send(input logic [31:0] va, input logic [1:0] ksu, input logic erl,
                        input logic exl, input logic st, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; st_ksu = ksu;
        st_erl = erl; st_exl = exl; req_store = st;
        sb.push_back(model(va, ksu, erl, exl, st, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_vaddr = 32'h8000_0040;  // would decode as direct if it leaked
            st_ksu = 2'd0; st_erl = 1'b0; st_exl = 1'b0; req_store = 1'b1;
        end
    endtask

    // Monitor: samples 2 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst && !done) begin
                if (rsp_valid) begin
                    checks++;
                    if (sb.size() == 0) begin
                        fails++;
                        $display("FAIL R9 unexpected rsp_valid: actual 1 expected 0");
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        if (rsp_tlb_req !== e.tlb || rsp_direct !== e.dir ||
                            rsp_cached !== e.cac || rsp_paddr !== e.pa ||
                            rsp_addr_err !== e.err || rsp_err_store !== e.est) begin
                            fails++;
                            $display("FAIL %s: actual tlb=%b dir=%b cac=%b pa=%h err=%b st=%b expected tlb=%b dir=%b cac=%b pa=%h err=%b st=%b",
                                     e.tag, rsp_tlb_req, rsp_direct, rsp_cached, rsp_paddr,
                                     rsp_addr_err, rsp_err_store, e.tlb, e.dir, e.cac, e.pa,
                                     e.err, e.est);
                        end
                    end
                end else if (sb.size() != 0) begin
                    checks++;
                    fails++;
                    $display("FAIL R9 missing rsp_valid: actual 0 expected 1 (%s)", sb[0].tag);
                    void'(sb.pop_front());
                end else begin
                    checks++;
                    if (rsp_tlb_req || rsp_direct || rsp_cached || rsp_addr_err ||
                        rsp_err_store || rsp_paddr != 0) begin
                        fails++;
                        $display("FAIL R9 idle outputs: actual tlb=%b dir=%b cac=%b pa=%h err=%b st=%b expected all 0",
                                 rsp_tlb_req, rsp_direct, rsp_cached, rsp_paddr,
                                 rsp_addr_err, rsp_err_store);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (rsp_valid !== 1'b0 || rsp_paddr !== 32'h0) begin
            fails++;
            $display("FAIL R9 reset state: actual valid=%b pa=%h expected valid=0 pa=0",
                     rsp_valid, rsp_paddr);
        end
        @(negedge clk);
        rst = 1'b0;
        idle(2);

        // R3 kernel cacheable window
        send(32'h8000_1234, 2'd0, 0, 0, 0, "R3 kseg cached");
        send(32'h8000_0000, 2'd0, 0, 0, 1, "R3 first word");
        send(32'h9FFF_FFFF, 2'd0, 0, 0, 0, "R3 last word");
        // R4 kernel uncached window
        send(32'hA000_0000, 2'd0, 0, 0, 0, "R4 first word");
        send(32'hBFFF_FFFC, 2'd0, 0, 0, 1, "R4 last word");
        // R5 kernel mapped
        send(32'h7FFF_FFFF, 2'd0, 0, 0, 0, "R5 below window");
        send(32'hC000_0000, 2'd0, 0, 0, 0, "R5 above window");
        send(32'hFFFF_FFFF, 2'd0, 0, 0, 1, "R5 top");
        idle(1);
        // R6 supervisor
        send(32'h0000_0010, 2'd1, 0, 0, 0, "R6 low legal");
        send(32'h1FFF_FFFF, 2'd1, 0, 0, 0, "R6 low edge");
        send(32'h2000_0000, 2'd1, 0, 0, 0, "R6 R8 low fault load");
        send(32'h8000_0000, 2'd1, 0, 0, 1, "R6 R8 direct fault store");
        send(32'hA000_0000, 2'd1, 0, 0, 0, "R6 uncached fault");
        send(32'hC000_0000, 2'd1, 0, 0, 0, "R6 high legal");
        send(32'hDFFF_FFFF, 2'd1, 0, 0, 1, "R6 high edge");
        send(32'hE000_0000, 2'd1, 0, 0, 1, "R6 R8 top fault store");
        idle(2);
        // R7 user
        send(32'h7FFF_FFFF, 2'd2, 0, 0, 1, "R7 legal");
        send(32'h8000_0000, 2'd2, 0, 0, 1, "R7 R8 fault store");
        send(32'h8000_0000, 2'd2, 0, 0, 0, "R7 R8 fault load");
        send(32'hC000_0000, 2'd2, 0, 0, 0, "R7 high fault");
        // R2 reserved code
        send(32'h8000_0040, 2'd3, 0, 0, 0, "R2 direct");
        send(32'hB000_0000, 2'd3, 0, 0, 1, "R2 uncached");
        send(32'h0000_0000, 2'd3, 0, 0, 0, "R2 mapped");
        idle(1);
        // R1 level bits force kernel
        send(32'h8000_0100, 2'd2, 1, 0, 1, "R1 erl user");
        send(32'hA000_0008, 2'd1, 0, 1, 0, "R1 exl super");
        send(32'hE000_0000, 2'd2, 0, 1, 1, "R1 exl user top");
        send(32'h9000_0000, 2'd1, 1, 1, 0, "R1 both bits");
        idle(3);

        @(posedge clk);
        #3;
        done = 1'b1;
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R9 leftover: actual %0d expected 0", sb.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule